// File: doc/BRIEF.md
# Two-Level Preemptive Process Scheduler

This block decides which process a processor core executes. Process identifiers arrive on an enqueue port tagged high or low, and wait in one first-in-first-out ready queue per level. A waiting high-level process always wins over low-level work. It may displace a running low-level process at an instruction boundary signalled by the core. The displaced low process is parked in a single shadow context. It returns once no high-level work remains, and it keeps its partly used timeslice.

High-level processes run until the core reports that they blocked or finished. Low-level processes share the core through timeslicing. A running low process is rotated to the tail of its queue after the second timeslice tick, at the next instruction boundary. This gives it between one and two tick periods of execution.

Each level owns two queue banks, an active one and an alternate one. A kernel can fill the alternate bank through a load port and then exchange the two banks with a single request. A running high-level process can read the shadow context on dedicated outputs and overwrite it.

Top module: `dual_level_sched`

## Requirements
- R1: While a low process runs and the high queue is non-empty, an instruction boundary with no block or done makes the head of the high queue run from the next cycle (`run_high`=1).
- R2: When the core is idle, or the running process blocks or finishes, the next process is picked in this order: high queue head, then the shadow context, then low queue head. The pick is visible one cycle later.
- R3: A running high process keeps the core, whatever the ticks and boundaries, until block or done is asserted.
- R4: Low processes are dispatched in enqueue order. A rotated low process is appended at the tail of the low queue and the head takes its place.
- R5: A newly dispatched low process starts with a fresh slice. The first tick arms the slice and the second makes it due. Rotation happens only when the slice is due and `bound`=1.
- R6: On preemption, the displaced low process identifier and its slice state go to the shadow context, and `shd_valid`=1.
- R7: A low process is never displaced (by preemption or rotation) in a cycle with `bound`=0.
- R8: A restored low process leaves the shadow empty (`shd_valid`=0) and continues with the slice state it had when displaced.
- R9: `swap_req` with `swap_high` selecting the level (1=high) exchanges that level's active and alternate banks from the next cycle. `alt_valid`/`alt_high` append `alt_pid` to the currently alternate bank.
- R10: While a high process runs and does not block or finish in that cycle, `shd_load` overwrites the shadow with `shd_load_pid` and `shd_load_valid`, with a fresh slice. The shadow is always visible on `shd_valid`/`shd_pid`.
- R11: An enqueue or alternate load into a queue that already holds DEPTH entries is dropped and pulses `enq_error` in the next cycle.
- R12: A due rotation is postponed by one cycle whenever a low-level enqueue request is present in the same cycle.
- R13: Synchronous reset empties all queues and the shadow, selects bank 0 for both levels, and clears `run_valid` and `enq_error`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enq_valid | input | 1 | Enqueue request to an active queue |
| enq_high | input | 1 | Level of the enqueue (1=high) |
| enq_pid | input | PID_W | Process identifier to enqueue |
| blk | input | 1 | Running process blocks (not re-queued) |
| done | input | 1 | Running process has completed |
| tick | input | 1 | Timeslice period tick |
| bound | input | 1 | Core is at an instruction boundary |
| swap_req | input | 1 | Exchange active and alternate bank of one level |
| swap_high | input | 1 | Level for the exchange (1=high) |
| alt_valid | input | 1 | Append to an alternate bank |
| alt_high | input | 1 | Level of the alternate append |
| alt_pid | input | PID_W | Identifier for the alternate bank |
| shd_load | input | 1 | Overwrite the shadow context |
| shd_load_valid | input | 1 | Valid flag written into the shadow |
| shd_load_pid | input | PID_W | Identifier written into the shadow |
| run_valid | output | 1 | A process is running |
| run_high | output | 1 | Running process level (1=high) |
| run_pid | output | PID_W | Running process identifier |
| shd_valid | output | 1 | Shadow holds a parked process |
| shd_pid | output | PID_W | Parked process identifier |
| enq_error | output | 1 | Previous cycle dropped a push on a full queue |

## Verification
The hazardous coincidences are a due rotation meeting a low-level enqueue, and a preemption or restore meeting a push or pop on the same queue. The first would put two writes into the low queue in one cycle. The second decides whether a process dispatched this cycle sees an entry that arrives in the same cycle. The bench provokes both directly: it lines up the second tick, a raised boundary and a low enqueue in one cycle, and it preempts while the high queue receives a new entry. A long random phase with dense ticks, boundaries, swaps and pushes near the full mark repeats these collisions many times. A queue-based model advanced on every edge judges every outcome through the running process, the shadow outputs and the error pulse.

// File: rtl/sched_pkg.sv
package sched_pkg;
  // slice progress of the running low-level process
  typedef enum logic [1:0] {
    SL_FRESH = 2'd0,
    SL_ARMED = 2'd1,
    SL_DUE   = 2'd2
  } slice_t;

  localparam int NLEVEL = 2;
  localparam int NBANK  = 2;
  localparam int NQUEUE = NLEVEL * NBANK;
endpackage

// File: rtl/sched_fifo.sv
module sched_fifo #(
  parameter int W     = 6,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_pop  = pop & ~empty;
  // a full queue accepts a push only while its head leaves in the same cycle
  assign do_push = push & (~full | do_pop);
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/sched_core.sv
module sched_core
  import sched_pkg::*;
#(
  parameter int PID_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             blk,
  input  logic             done,
  input  logic             tick,
  input  logic             bound,
  input  logic             ext_lo_req,
  input  logic             hi_empty,
  input  logic             lo_empty,
  input  logic [PID_W-1:0] hi_head,
  input  logic [PID_W-1:0] lo_head,
  input  logic             shd_load,
  input  logic             shd_load_valid,
  input  logic [PID_W-1:0] shd_load_pid,
  output logic             pop_hi,
  output logic             pop_lo,
  output logic             rot_push,
  output logic [PID_W-1:0] rot_pid,
  output logic             run_valid,
  output logic             run_high,
  output logic [PID_W-1:0] run_pid,
  output slice_t           slice_q,
  output logic             shd_valid,
  output logic [PID_W-1:0] shd_pid
);
  slice_t shd_slice;
  logic   lo_run, hi_run, rel, free;
  logic   take_hi, preempt, restore, take_lo, due, rot_swap;

  always_comb begin
    lo_run   = run_valid & ~run_high;
    hi_run   = run_valid & run_high;
    rel      = run_valid & (blk | done);
    free     = ~run_valid | rel;
    take_hi  = ~hi_empty & (free | (lo_run & bound));
    preempt  = take_hi & lo_run & ~rel;
    restore  = ~take_hi & free & shd_valid;
    take_lo  = ~take_hi & free & ~shd_valid & ~lo_empty;
    due      = lo_run & ~rel & ~take_hi & (slice_q == SL_DUE) & bound & ~ext_lo_req;
    rot_swap = due & ~lo_empty;
  end

  assign pop_hi   = take_hi;
  assign pop_lo   = take_lo | rot_swap;
  assign rot_push = rot_swap;
  assign rot_pid  = run_pid;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_valid <= 1'b0;
      run_high  <= 1'b0;
      run_pid   <= '0;
      slice_q   <= SL_FRESH;
      shd_valid <= 1'b0;
      shd_pid   <= '0;
      shd_slice <= SL_FRESH;
    end else begin
      if (take_hi) begin
        run_valid <= 1'b1;
        run_high  <= 1'b1;
        run_pid   <= hi_head;
        slice_q   <= SL_FRESH;
        if (preempt) begin
          shd_valid <= 1'b1;
          shd_pid   <= run_pid;
          shd_slice <= slice_q;
        end
      end else if (restore) begin
        run_valid <= 1'b1;
        run_high  <= 1'b0;
        run_pid   <= shd_pid;
        slice_q   <= shd_slice;
        shd_valid <= 1'b0;
      end else if (take_lo) begin
        run_valid <= 1'b1;
        run_high  <= 1'b0;
        run_pid   <= lo_head;
        slice_q   <= SL_FRESH;
      end else if (rel) begin
        run_valid <= 1'b0;
        run_high  <= 1'b0;
        slice_q   <= SL_FRESH;
      end else if (due) begin
        if (!lo_empty) run_pid <= lo_head;
        slice_q <= SL_FRESH;
      end else if (lo_run && tick && slice_q != SL_DUE) begin
        slice_q <= (slice_q == SL_FRESH) ? SL_ARMED : SL_DUE;
      end

      if (shd_load && hi_run && !rel) begin
        shd_valid <= shd_load_valid;
        shd_pid   <= shd_load_pid;
        shd_slice <= SL_FRESH;
      end
    end
  end
endmodule

// File: rtl/dual_level_sched.sv
module dual_level_sched
  import sched_pkg::*;
#(
  parameter int PID_W = 6,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enq_valid,
  input  logic             enq_high,
  input  logic [PID_W-1:0] enq_pid,
  input  logic             blk,
  input  logic             done,
  input  logic             tick,
  input  logic             bound,
  input  logic             swap_req,
  input  logic             swap_high,
  input  logic             alt_valid,
  input  logic             alt_high,
  input  logic [PID_W-1:0] alt_pid,
  input  logic             shd_load,
  input  logic             shd_load_valid,
  input  logic [PID_W-1:0] shd_load_pid,
  output logic             run_valid,
  output logic             run_high,
  output logic [PID_W-1:0] run_pid,
  output logic             shd_valid,
  output logic [PID_W-1:0] shd_pid,
  output logic             enq_error
);
  logic [NQUEUE-1:0] f_push, f_pop, f_empty, f_full;
  logic [PID_W-1:0]  f_din  [NQUEUE];
  logic [PID_W-1:0]  f_head [NQUEUE];
  logic [NLEVEL-1:0] bank_sel;

  logic             pop_hi, pop_lo, rot_push;
  logic [PID_W-1:0] rot_pid;
  logic             hi_empty_w, lo_empty_w, enq_full, alt_full;
  logic [PID_W-1:0] hi_head_w, lo_head_w;
  slice_t           slice_w;

  // queue index = level*2 + bank
  assign hi_empty_w = f_empty[{1'b1, bank_sel[1]}];
  assign lo_empty_w = f_empty[{1'b0, bank_sel[0]}];
  assign hi_head_w  = f_head[{1'b1, bank_sel[1]}];
  assign lo_head_w  = f_head[{1'b0, bank_sel[0]}];
  assign enq_full   = f_full[{enq_high, bank_sel[enq_high]}];
  assign alt_full   = f_full[{alt_high, ~bank_sel[alt_high]}];

  for (genvar g = 0; g < NQUEUE; g++) begin : g_q
    localparam int LVL = g / NBANK;
    localparam int BNK = g % NBANK;
    logic act, ext_w, alt_w, rot_w;

    always_comb begin
      act   = (bank_sel[LVL] == 1'(BNK));
      ext_w = enq_valid & (enq_high == 1'(LVL)) & act & ~f_full[g];
      alt_w = alt_valid & (alt_high == 1'(LVL)) & ~act & ~f_full[g];
      rot_w = (LVL == 0) & act & rot_push;
      f_push[g] = ext_w | alt_w | rot_w;
      f_din[g]  = ext_w ? enq_pid : (alt_w ? alt_pid : rot_pid);
      f_pop[g]  = act & ((LVL == 1) ? pop_hi : pop_lo);
    end

    sched_fifo #(.W(PID_W), .DEPTH(DEPTH)) u_fifo (
      .clk   (clk),
      .rst   (rst),
      .push  (f_push[g]),
      .pop   (f_pop[g]),
      .din   (f_din[g]),
      .head  (f_head[g]),
      .empty (f_empty[g]),
      .full  (f_full[g])
    );
  end

  sched_core #(.PID_W(PID_W)) u_core (
    .clk            (clk),
    .rst            (rst),
    .blk            (blk),
    .done           (done),
    .tick           (tick),
    .bound          (bound),
    .ext_lo_req     (enq_valid & ~enq_high),
    .hi_empty       (hi_empty_w),
    .lo_empty       (lo_empty_w),
    .hi_head        (hi_head_w),
    .lo_head        (lo_head_w),
    .shd_load       (shd_load),
    .shd_load_valid (shd_load_valid),
    .shd_load_pid   (shd_load_pid),
    .pop_hi         (pop_hi),
    .pop_lo         (pop_lo),
    .rot_push       (rot_push),
    .rot_pid        (rot_pid),
    .run_valid      (run_valid),
    .run_high       (run_high),
    .run_pid        (run_pid),
    .slice_q        (slice_w),
    .shd_valid      (shd_valid),
    .shd_pid        (shd_pid)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_sel  <= '0;
      enq_error <= 1'b0;
    end else begin
      enq_error <= (enq_valid & enq_full) | (alt_valid & alt_full);
      if (swap_req) bank_sel[swap_high] <= ~bank_sel[swap_high];
    end
  end
endmodule

// File: rtl/sched_checker.sv
module sched_checker #(
  parameter int PID_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             enq_valid,
  input logic             enq_high,
  input logic             blk,
  input logic             done,
  input logic             bound,
  input logic             swap_req,
  input logic             swap_high,
  input logic             run_valid,
  input logic             run_high,
  input logic [PID_W-1:0] run_pid,
  input logic             shd_valid,
  input logic [PID_W-1:0] shd_pid,
  input logic             enq_error,
  input logic             hi_empty,
  input logic             enq_full,
  input logic [1:0]       slice_w,
  input logic [1:0]       bank_sel
);
  logic lo_stay;
  assign lo_stay = run_valid & ~run_high & ~blk & ~done;

  a_r1_high_first: assert property (@(posedge clk) disable iff (rst)
    lo_stay && !hi_empty && bound |=> run_valid && run_high);

  a_r2_idle_dispatch: assert property (@(posedge clk) disable iff (rst)
    !run_valid && !hi_empty |=> run_valid && run_high);

  a_r3_high_keeps: assert property (@(posedge clk) disable iff (rst)
    run_valid && run_high && !blk && !done |=> run_valid && run_high && run_pid == $past(run_pid));

  a_r5_slice_not_due: assert property (@(posedge clk) disable iff (rst)
    lo_stay && hi_empty && slice_w != 2'd2 |=> run_valid && !run_high && run_pid == $past(run_pid));

  a_r6_park: assert property (@(posedge clk) disable iff (rst)
    lo_stay && !hi_empty && bound |=> shd_valid && shd_pid == $past(run_pid));

  a_r7_boundary: assert property (@(posedge clk) disable iff (rst)
    lo_stay && !bound |=> run_valid && !run_high && run_pid == $past(run_pid));

  a_r8_restore: assert property (@(posedge clk) disable iff (rst)
    run_valid && run_high && (blk || done) && hi_empty && shd_valid
    |=> run_valid && !run_high && !shd_valid && run_pid == $past(shd_pid));

  a_r9_swap: assert property (@(posedge clk) disable iff (rst)
    swap_req |=> bank_sel[$past(swap_high)] != $past(bank_sel[swap_high]));

  a_r11_overflow: assert property (@(posedge clk) disable iff (rst)
    enq_valid && enq_full |=> enq_error);

  a_r12_postpone: assert property (@(posedge clk) disable iff (rst)
    lo_stay && hi_empty && enq_valid && !enq_high |=> run_pid == $past(run_pid));

  a_r13_reset: assert property (@(posedge clk)
    rst |=> !run_valid && !shd_valid && !enq_error && bank_sel == 2'b00);

  always_comb begin
    a_r6_shadow_low: assert (rst || !shd_valid || !run_valid || run_high);
  end
endmodule

bind dual_level_sched sched_checker #(.PID_W(PID_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .enq_valid (enq_valid),
  .enq_high  (enq_high),
  .blk       (blk),
  .done      (done),
  .bound     (bound),
  .swap_req  (swap_req),
  .swap_high (swap_high),
  .run_valid (run_valid),
  .run_high  (run_high),
  .run_pid   (run_pid),
  .shd_valid (shd_valid),
  .shd_pid   (shd_pid),
  .enq_error (enq_error),
  .hi_empty  (hi_empty_w),
  .enq_full  (enq_full),
  .slice_w   (slice_w),
  .bank_sel  (bank_sel)
);

// File: tb/dual_level_sched_bench.sv
`timescale 1ns/1ps
module dual_level_sched_bench;
  localparam int PID_W = 6;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enq_valid, enq_high, blk, done, tick, bound;
  logic swap_req, swap_high, alt_valid, alt_high, shd_load, shd_load_valid;
  logic [PID_W-1:0] enq_pid, alt_pid, shd_load_pid;
  logic run_valid, run_high, shd_valid, enq_error;
  logic [PID_W-1:0] run_pid, shd_pid;

  always #2.5 clk = ~clk;

  dual_level_sched #(.PID_W(PID_W), .DEPTH(DEPTH)) u_dual_level_sched (
    .clk(clk), .rst(rst), .enq_valid(enq_valid), .enq_high(enq_high), .enq_pid(enq_pid),
    .blk(blk), .done(done), .tick(tick), .bound(bound),
    .swap_req(swap_req), .swap_high(swap_high),
    .alt_valid(alt_valid), .alt_high(alt_high), .alt_pid(alt_pid),
    .shd_load(shd_load), .shd_load_valid(shd_load_valid), .shd_load_pid(shd_load_pid),
    .run_valid(run_valid), .run_high(run_high), .run_pid(run_pid),
    .shd_valid(shd_valid), .shd_pid(shd_pid), .enq_error(enq_error)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    finished = 0;
  string tag = "R13 reset";

  // behavioural reference: queue index = level*2 + bank
  int mq [4][$];
  bit m_cv, m_ch, m_sv, m_err;
  int m_pid, m_sl, m_spid, m_ssl;
  bit m_sel [2];

  task automatic m_reset();
    for (int i = 0; i < 4; i++) mq[i].delete();
    m_cv = 0; m_ch = 0; m_sv = 0; m_err = 0;
    m_pid = 0; m_sl = 0; m_spid = 0; m_ssl = 0;
    m_sel[0] = 0; m_sel[1] = 0;
  endtask

  task automatic m_step();
    int hq = 2 + int'(m_sel[1]);
    int lq = int'(m_sel[0]);
    int sz [4];
    int eq, aq;
    bit lo_run, hi_run, rel, free, take_hi, restore, take_lo, due;
    for (int i = 0; i < 4; i++) sz[i] = mq[i].size();
    lo_run  = m_cv && !m_ch;
    hi_run  = m_cv && m_ch;
    rel     = m_cv && (blk || done);
    free    = !m_cv || rel;
    take_hi = sz[hq] > 0 && (free || (lo_run && bound));
    restore = !take_hi && free && m_sv;
    take_lo = !take_hi && free && !m_sv && sz[lq] > 0;
    due     = lo_run && !rel && !take_hi && m_sl == 2 && bound && !(enq_valid && !enq_high);
    if (take_hi) begin
      if (lo_run && !rel) begin
        m_sv = 1; m_spid = m_pid; m_ssl = m_sl;
      end
      m_pid = mq[hq].pop_front(); m_cv = 1; m_ch = 1; m_sl = 0;
    end else if (restore) begin
      m_pid = m_spid; m_cv = 1; m_ch = 0; m_sl = m_ssl; m_sv = 0;
    end else if (take_lo) begin
      m_pid = mq[lq].pop_front(); m_cv = 1; m_ch = 0; m_sl = 0;
    end else if (rel) begin
      m_cv = 0; m_ch = 0; m_sl = 0;
    end else if (due) begin
      if (sz[lq] > 0) begin
        mq[lq].push_back(m_pid);
        m_pid = mq[lq].pop_front();
      end
      m_sl = 0;
    end else if (lo_run && tick && m_sl < 2) begin
      m_sl++;
    end
    if (shd_load && hi_run && !rel) begin
      m_sv = shd_load_valid; m_spid = int'(shd_load_pid); m_ssl = 0;
    end
    eq = enq_high ? 2 + int'(m_sel[1]) : int'(m_sel[0]);
    aq = alt_high ? 2 + int'(!m_sel[1]) : int'(!m_sel[0]);
    if (enq_valid && sz[eq] < DEPTH) mq[eq].push_back(int'(enq_pid));
    if (alt_valid && sz[aq] < DEPTH) mq[aq].push_back(int'(alt_pid));
    m_err = (enq_valid && sz[eq] >= DEPTH) || (alt_valid && sz[aq] >= DEPTH);
    if (swap_req) m_sel[swap_high] = !m_sel[swap_high];
  endtask

  always @(posedge clk) begin
    if (rst) m_reset();
    else     m_step();
  end

  task automatic chk(bit ok, string what, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL [%s] %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    chk(run_valid == m_cv, "run_valid", int'(run_valid), int'(m_cv));
    if (m_cv) begin
      chk(run_high == m_ch, "run_high", int'(run_high), int'(m_ch));
      chk(int'(run_pid) == m_pid, "run_pid", int'(run_pid), m_pid);
    end
    chk(shd_valid == m_sv, "shd_valid", int'(shd_valid), int'(m_sv));
    if (m_sv) chk(int'(shd_pid) == m_spid, "shd_pid", int'(shd_pid), m_spid);
    chk(enq_error == m_err, "enq_error", int'(enq_error), int'(m_err));
  endtask

  task automatic idle_in();
    enq_valid = 0; enq_high = 0; enq_pid = '0; blk = 0; done = 0; tick = 0; bound = 1;
    swap_req = 0; swap_high = 0; alt_valid = 0; alt_high = 0; alt_pid = '0;
    shd_load = 0; shd_load_valid = 0; shd_load_pid = '0;
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
    compare();
    idle_in();
  endtask

  task automatic put(bit hi, int pid);
    enq_valid = 1; enq_high = hi; enq_pid = PID_W'(pid);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL [watchdog] run did not end actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    idle_in();
    rst = 1;
    repeat (3) cyc();
    rst = 0;
    chk(run_valid == 0 && shd_valid == 0, "R13 idle after reset", int'(run_valid), 0);

    tag = "R4 R5 R12 low order and slicing";
    put(0, 10); cyc();
    put(0, 11); cyc();
    chk(int'(run_pid) == 10, "R4 first low dispatched", int'(run_pid), 10);
    put(0, 12); cyc();
    tick = 1; cyc();
    cyc();
    tick = 1; bound = 0; cyc();
    chk(int'(run_pid) == 10, "R5 still running after two ticks without boundary", int'(run_pid), 10);
    put(0, 13); cyc();
    chk(int'(run_pid) == 10, "R12 rotation postponed by low enqueue", int'(run_pid), 10);
    cyc();
    chk(int'(run_pid) == 11, "R4 rotation takes queue head", int'(run_pid), 11);

    tag = "R1 R6 R7 R8 preemption";
    put(1, 40); bound = 0; cyc();
    bound = 0; cyc();
    chk(run_high == 0, "R7 no preemption off boundary", int'(run_high), 0);
    put(1, 41); cyc();
    chk(run_high == 1 && int'(run_pid) == 40, "R1 high preempts", int'(run_pid), 40);
    chk(int'(shd_pid) == 11, "R6 shadow holds displaced", int'(shd_pid), 11);
    done = 1; cyc();
    blk = 1; cyc();
    chk(run_high == 0 && int'(run_pid) == 11, "R8 displaced process resumes", int'(run_pid), 11);

    tag = "R3 R10 high run and shadow access";
    put(1, 42); cyc();
    cyc();
    repeat (5) begin tick = 1; cyc(); end
    chk(int'(run_pid) == 42, "R3 high not sliced", int'(run_pid), 42);
    shd_load = 1; shd_load_valid = 1; shd_load_pid = 6'd55; cyc();
    chk(int'(shd_pid) == 55, "R10 shadow loaded", int'(shd_pid), 55);
    done = 1; cyc();
    chk(int'(run_pid) == 55 && run_high == 0, "R2 shadow before low queue", int'(run_pid), 55);

    tag = "R9 bank exchange";
    alt_valid = 1; alt_high = 1; alt_pid = 6'd33; cyc();
    alt_valid = 1; alt_high = 1; alt_pid = 6'd34; cyc();
    swap_req = 1; swap_high = 1; cyc();
    cyc();
    chk(int'(run_pid) == 33 && run_high == 1, "R9 swapped bank dispatched", int'(run_pid), 33);

    tag = "R11 overflow";
    begin
      int errs = 0;
      for (int i = 0; i < DEPTH + 2; i++) begin
        put(1, 20 + i); cyc();
        if (enq_error) errs++;
      end
      cyc();
      if (enq_error) errs++;
      chk(errs > 0, "R11 overflow flagged", errs, 1);
    end
    repeat (DEPTH + 4) begin done = 1; cyc(); end

    tag = "R1 R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 R12 random mix";
    for (int c = 0; c < 6000; c++) begin
      enq_valid = ($urandom_range(0, 99) < 45);
      enq_high  = ($urandom_range(0, 99) < 35);
      enq_pid   = PID_W'($urandom_range(0, 63));
      blk       = ($urandom_range(0, 99) < 6);
      done      = ($urandom_range(0, 99) < 5);
      tick      = ($urandom_range(0, 99) < 30);
      bound     = ($urandom_range(0, 99) < 65);
      swap_req  = ($urandom_range(0, 99) < 3);
      swap_high = $urandom_range(0, 1);
      alt_valid = ($urandom_range(0, 99) < 12);
      alt_high  = $urandom_range(0, 1);
      alt_pid   = PID_W'($urandom_range(0, 63));
      shd_load  = ($urandom_range(0, 99) < 5);
      shd_load_valid = $urandom_range(0, 1);
      shd_load_pid   = PID_W'($urandom_range(0, 63));
      cyc();
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule